// File: doc/BRIEF.md
# Field-Loadable Sum-of-Products Array

This block evaluates a set of Boolean functions in two programmable levels. An AND plane forms a group of product terms. Each product term uses any mix of true inputs, complemented inputs and ignored inputs. An OR plane then gathers any subset of those terms into each output. A term can feed any number of outputs, so one term can serve several functions without being built again. The outputs are a purely combinational function of the logic inputs and of the stored configuration.

Both planes are held in one configuration register chain. The chain is loaded serially on a configuration clock while a load-enable input is high. Reset puts every connection in place: each literal connects both polarities and each OR entry is closed. The usual way to use the block is to reset it, shift in a complete personality, and then drop the enable. After that the inputs are driven freely.

Top module: `sop_array`

## Requirements
- R1: Each AND-plane literal is a 2-bit code per input per term. 00 leaves the input out of the term, 01 requires the input to be 1, and 10 requires the input to be 0. A term is the AND of all its literals.
- R2: A literal code of 11 requires the input to be both 1 and 0, so that term is 0 for every input value.
- R3: A term whose literals are all 00 evaluates to 1.
- R4: OR-plane bit p of output o is 1 when term p is connected to output o. Each output is the OR of its connected terms, and one term may be connected to several outputs.
- R5: An output with no connected terms is 0 for every input value.
- R6: After reset every literal is 11 and every OR bit is 1, so all outputs are 0 for any input.
- R7: On each rising configuration-clock edge with the load enable high, the chain shifts in one bit. The stream has 2·N·P AND bits followed by M·P OR bits. AND bits go term 0 first. Within a term, input N-1 comes first, and each code is sent high bit first. OR bits go output 0 first, and within an output term P-1 comes first.
- R8: While the load enable is high, every output is 0.
- R9: While the load enable is low, the configuration does not change, whatever happens on the serial data input.
- R10: With the load enable low, a change of the logic inputs shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfgClk | input | 1 | Configuration shift clock |
| cfgRstN | input | 1 | Asynchronous active-low reset of the configuration |
| cfgEn | input | 1 | Load enable; shifts the chain and blanks the outputs |
| cfgDin | input | 1 | Serial configuration data |
| inVec | input | N | Logic inputs |
| outVec | output | M | Function outputs |

## Verification
The checks that run on every cycle cover the serial chain and the output blanking. They confirm that each enabled edge moves the chain by exactly one bit with the new bit at the bottom. They confirm that the chain keeps its value when the enable is low, and that the outputs are zero while loading. They also confirm two literal corner cases for every term: an all-ignored term reads 1, and any 11 code forces the term to 0. The bench scenarios are what show the bit ordering of the stream and the reset personality. They also show correct sharing of terms across outputs, and that outputs with no connected terms stay low. For this, the bench loads two personalities and compares every input combination against a model built from the requirements.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef struct packed {
    logic shiftEn;
    logic holdOut;
  } cfgStrobe_t;
endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
(
  input  logic       cfgEn,
  output cfgStrobe_t strobe
);
  always_comb begin
    strobe.shiftEn = cfgEn;
    strobe.holdOut = cfgEn;
  end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_pkg::*;
#(
  parameter int N = 4,
  parameter int P = 8,
  parameter int M = 4
) (
  input  logic                      cfgClk,
  input  logic                      cfgRstN,
  input  cfgStrobe_t                strobe,
  input  logic                      cfgDin,
  output logic [P-1:0][2*N-1:0]     andPlane,
  output logic [M-1:0][P-1:0]       orPlane
);
  localparam int AndBits = 2 * N * P;
  localparam int OrBits  = M * P;
  localparam int ChainLen = AndBits + OrBits;

  logic [ChainLen-1:0] cfgBits;

  always_ff @(posedge cfgClk or negedge cfgRstN) begin
    if (!cfgRstN) cfgBits <= '1;
    else if (strobe.shiftEn) cfgBits <= {cfgBits[ChainLen-2:0], cfgDin};
  end

  for (genvar t = 0; t < P; t++) begin : g_andSlice
    assign andPlane[t] = cfgBits[OrBits + (P-1-t)*2*N +: 2*N];
  end
  for (genvar o = 0; o < M; o++) begin : g_orSlice
    assign orPlane[o] = cfgBits[(M-1-o)*P +: P];
  end

  // R7: one bit per enabled edge, new bit at the bottom
  a_r7_shift_one: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    strobe.shiftEn |=> (cfgBits[0] == $past(cfgDin)) &&
                       (cfgBits[ChainLen-1:1] == $past(cfgBits[ChainLen-2:0])));
  // R9: configuration is frozen while not loading
  a_r9_cfg_frozen: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    !strobe.shiftEn |=> $stable(cfgBits));
endmodule

// File: rtl/sop_eval.sv
module sop_eval #(
  parameter int N = 4,
  parameter int P = 8,
  parameter int M = 4
) (
  input  logic [N-1:0]              inVec,
  input  logic [P-1:0][2*N-1:0]     andPlane,
  input  logic [M-1:0][P-1:0]       orPlane,
  input  logic                      holdOut,
  output logic [M-1:0]              outVec
);
  logic [P-1:0][N-1:0] litOk;
  logic [P-1:0]        termVec;
  logic [M-1:0]        rawOut;

  for (genvar t = 0; t < P; t++) begin : g_term
    for (genvar i = 0; i < N; i++) begin : g_lit
      // bit0 of the code: true literal present, bit1: complemented literal present
      assign litOk[t][i] = (~andPlane[t][2*i]   |  inVec[i]) &
                           (~andPlane[t][2*i+1] | ~inVec[i]);
    end
    assign termVec[t] = &litOk[t];

    always_comb begin
      if (andPlane[t] == '0) begin
        a_r3_free_term: assert (termVec[t] == 1'b1);
      end
      for (int i = 0; i < N; i++) begin
        if (andPlane[t][2*i +: 2] == 2'b11) begin
          a_r2_clash_term: assert (termVec[t] == 1'b0);
        end
      end
    end
  end

  for (genvar o = 0; o < M; o++) begin : g_out
    assign rawOut[o] = |(termVec & orPlane[o]);
  end

  assign outVec = holdOut ? '0 : rawOut;
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N = 4,
  parameter int P = 8,
  parameter int M = 4
) (
  input  logic         cfgClk,
  input  logic         cfgRstN,
  input  logic         cfgEn,
  input  logic         cfgDin,
  input  logic [N-1:0] inVec,
  output logic [M-1:0] outVec
);
  cfgStrobe_t              strobe;
  logic [P-1:0][2*N-1:0]   andPlane;
  logic [M-1:0][P-1:0]     orPlane;

  sop_ctrl uCtrl (.cfgEn(cfgEn), .strobe(strobe));

  sop_cfg_store #(.N(N), .P(P), .M(M)) uStore (
    .cfgClk(cfgClk), .cfgRstN(cfgRstN), .strobe(strobe), .cfgDin(cfgDin),
    .andPlane(andPlane), .orPlane(orPlane));

  sop_eval #(.N(N), .P(P), .M(M)) uEval (
    .inVec(inVec), .andPlane(andPlane), .orPlane(orPlane),
    .holdOut(strobe.holdOut), .outVec(outVec));

  // R8: outputs blanked whenever loading
  a_r8_blank_load: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    cfgEn |-> (outVec == '0));
endmodule

// File: tb/sim_sop_array.sv
module sim_sop_array;
  localparam int N = 4;
  localparam int P = 8;
  localparam int M = 4;
  localparam int CLK_PERIOD = 10;

  logic cfgClk = 1'b0;
  logic cfgRstN = 1'b0;
  logic cfgEn = 1'b0;
  logic cfgDin = 1'b0;
  logic [N-1:0] inVec = '0;
  logic [M-1:0] outVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [M-1:0] exp;
    string        tag;
    logic [N-1:0] stim;
  } item_t;
  item_t expQ[$];

  logic [1:0] lit [P][N];
  logic       conn[M][P];

  sop_array #(.N(N), .P(P), .M(M)) u0 (
    .cfgClk(cfgClk), .cfgRstN(cfgRstN), .cfgEn(cfgEn), .cfgDin(cfgDin),
    .inVec(inVec), .outVec(outVec));

  always #(CLK_PERIOD/2) cfgClk = ~cfgClk;

  function automatic logic [M-1:0] model(input logic [N-1:0] x);
    logic [P-1:0] term;
    logic [M-1:0] y;
    for (int t = 0; t < P; t++) begin
      term[t] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (lit[t][i][0] && !x[i]) term[t] = 1'b0;
        if (lit[t][i][1] &&  x[i]) term[t] = 1'b0;
      end
    end
    for (int o = 0; o < M; o++) begin
      y[o] = 1'b0;
      for (int t = 0; t < P; t++) if (conn[o][t] && term[t]) y[o] = 1'b1;
    end
    return y;
  endfunction

  task automatic drive(input logic [N-1:0] x, input logic [M-1:0] e, input string tag);
    item_t it;
    @(negedge cfgClk);
    inVec = x;
    it.exp = e; it.tag = tag; it.stim = x;
    expQ.push_back(it);
  endtask

  task automatic clearPers();
    for (int t = 0; t < P; t++) for (int i = 0; i < N; i++) lit[t][i] = 2'b00;
    for (int o = 0; o < M; o++) for (int t = 0; t < P; t++) conn[o][t] = 1'b0;
  endtask

  // R7 stream order; blank check for R8 in the middle of the load
  task automatic loadPers(input logic [N-1:0] midStim);
    int k = 0;
    logic bits[$];
    item_t it;
    for (int t = 0; t < P; t++)
      for (int i = N-1; i >= 0; i--) begin
        bits.push_back(lit[t][i][1]);
        bits.push_back(lit[t][i][0]);
      end
    for (int o = 0; o < M; o++)
      for (int t = P-1; t >= 0; t--) bits.push_back(conn[o][t]);
    foreach (bits[j]) begin
      @(negedge cfgClk);
      cfgEn = 1'b1;
      cfgDin = bits[j];
      if (k == bits.size()/2) begin
        inVec = midStim;
        it.exp = '0; it.tag = "R8"; it.stim = midStim;
        expQ.push_back(it);
      end
      k++;
    end
    @(negedge cfgClk);
    cfgEn = 1'b0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge cfgClk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (outVec !== it.exp) begin
          errors++;
          $display("FAIL %s in=%b actual=%b expected=%b", it.tag, it.stim, outVec, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R6: reset personality blanks every output
    repeat (3) @(negedge cfgClk);
    cfgRstN = 1'b1;
    for (int x = 0; x < 16; x += 5) drive(N'(x), '0, "R6");

    // Personality 1: A=in[2], B=in[1], C=in[0]; in[3] ignored
    clearPers();
    lit[0][2] = 2'b01;                      // t0 = A
    lit[1][1] = 2'b10; lit[1][0] = 2'b01;   // t1 = B'C
    lit[2][2] = 2'b01; lit[2][0] = 2'b10;   // t2 = AC'
    lit[3][2] = 2'b01; lit[3][1] = 2'b01;   // t3 = AB
    lit[4][1] = 2'b10; lit[4][0] = 2'b10;   // t4 = B'C'
    for (int t = 5; t < P; t++) lit[t][3] = 2'b11;  // R2: dead terms
    conn[0][0] = 1; conn[0][1] = 1; conn[0][5] = 1;
    conn[1][2] = 1; conn[1][3] = 1;
    conn[2][4] = 1; conn[2][3] = 1;
    conn[3][1] = 1; conn[3][0] = 1; conn[3][6] = 1;
    loadPers(4'b0100);
    // R1 R2 R4 R7: shared terms over all input combinations
    for (int x = 0; x < 16; x++) drive(N'(x), model(N'(x)), "R1/R2/R4/R7");

    // R9: serial data toggling with enable low leaves the personality intact
    for (int c = 0; c < 20; c++) begin
      @(negedge cfgClk);
      cfgDin = c[0] ^ c[2];
    end
    for (int x = 0; x < 16; x += 3) drive(N'(x), model(N'(x)), "R9");

    // R10: combinational response without a clock edge
    for (int x = 0; x < 4; x++) begin
      @(negedge cfgClk);
      inVec = N'(x * 5);
      #1;
      checks++;
      if (outVec !== model(N'(x * 5))) begin
        errors++;
        $display("FAIL R10 in=%b actual=%b expected=%b", inVec, outVec, model(N'(x * 5)));
      end
    end

    // Personality 2: free term, empty outputs
    clearPers();
    lit[1][3] = 2'b01; lit[1][0] = 2'b10;  // t1 = in3 & ~in0
    for (int t = 2; t < P; t++) lit[t][0] = 2'b11;
    conn[3][0] = 1;                         // R3: out3 constant 1
    conn[2][1] = 1;
    loadPers(4'b0101);
    // R3 R5: outputs 0 and 1 stay low, out3 high
    for (int x = 0; x < 16; x++) drive(N'(x), model(N'(x)), "R3/R5");

    wait (expQ.size() == 0);
    @(negedge cfgClk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule